// File: doc/BRIEF.md
# I2C Slave Select and Framing Front End

This block is the bus-facing half of a two-wire serial slave. It synchronizes the raw clock and data lines to the system clock, finds START, repeated START and STOP conditions, and shifts bytes in most significant bit first. The first byte after any START is a select byte. The block compares it against two 4-bit device type codes, one for a storage array and one for a protection register, and against three chip-enable pins. It acknowledges a match by pulling the data line low in the ninth clock. The protection-register code can be switched off at runtime.

After a write selection, each further byte goes to downstream logic on a one-cycle strobe. The block acknowledges the byte only if the downstream ack-enable input allows it. A STOP that arrives in the slot right after such an acknowledge raises a one-cycle write-trigger flag. After a read selection, the block fetches bytes from a downstream data input and shifts them out. It continues while the master acknowledges and stops at the master's NoAck. While the busy input is high, the block ignores the bus completely.

Top module: `i2c_sel_front`

## Requirements
- R1: After reset, `sdaOe` is 0, `selActive` is 0, `selTarget` is 2'b00, and no strobe is active.
- R2: The select byte is read as bits 7:4 = type code, bits 3:1 = chip-enable address, bit 0 = RW (1 read, 0 write). Type code 4'b1010 with bits 3:1 equal to `chipEn` is acknowledged in the ninth clock. It sets `selActive`, `selTarget` = 2'b01 and `rwBit` = bit 0.
- R3: Type code 4'b0110 with a matching address is acknowledged with `selTarget` = 2'b10 when `protEnable` is 1. When `protEnable` is 0 the byte is not acknowledged.
- R4: Any other type code, or a chip-enable address that differs from `chipEn`, gets no acknowledge. The block then stays idle until the next START: it sends no ack, no `rxStrobe` and no `rdLoad`.
- R5: In a write selection, each following byte is assembled MSB first. It is presented on `rxByte` with a one-cycle `rxStrobe` on the SCL fall that ends its eighth bit. In that same cycle `ackEnable` is sampled, and it decides whether the ninth clock is acknowledged. After a NoAck the block goes idle.
- R6: A STOP right after an acknowledged data byte of a write gives exactly one `writeTrig` pulse. A STOP in any other slot gives none. Other slots include a STOP after the select acknowledge only, a STOP mid-byte, and a STOP after a NoAck.
- R7: In a read selection, the block samples `rdData` and pulses `rdLoad` on the SCL fall that ends each acknowledge slot. It drives the byte MSB first: a 0 bit pulls SDA low. It releases SDA in the ninth clock. A master ack (0) starts the next byte. A master NoAck (1) leaves SDA released until the next START. SDA only changes while SCL is low.
- R8: A START at any point clears the bit count and restarts select-byte reception.
- R9: While `busy` is 1, SCL and SDA are ignored. No select byte is acknowledged, no strobe fires, and `sdaOe` and `selActive` are 0 from the next cycle.
- R10: A STOP clears `selActive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw serial clock line |
| sdaIn | input | 1 | Raw serial data line (resolved bus level) |
| sdaOe | output | 1 | 1 pulls the data line low (open drain) |
| chipEn | input | 3 | Chip-enable address to match against select bits 3:1 |
| protEnable | input | 1 | 1 allows the protection-register type code |
| ackEnable | input | 1 | Downstream permission to acknowledge a written data byte |
| busy | input | 1 | Internal write in progress; bus ignored |
| rdData | input | 8 | Next byte to transmit in a read |
| rdLoad | output | 1 | Pulse: `rdData` taken for transmission |
| selActive | output | 1 | A select byte matched and the transfer is live |
| selTarget | output | 2 | 2'b01 array, 2'b10 protection register, 2'b00 none |
| rwBit | output | 1 | RW bit of the current selection |
| rxByte | output | 8 | Last received data byte |
| rxStrobe | output | 1 | Pulse: `rxByte` holds a new data byte |
| writeTrig | output | 1 | Pulse: STOP arrived right after an acknowledged data byte |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to form START and STOP. It does not form either condition while the slave holds SDA low. It holds `busy` for more than one cycle. The bench drives SCL and SDA from bit-level tasks in which each phase lasts five system clocks. Data moves only inside the SCL-low phase, and START and STOP happen only with the line released, so every check stays inside those assumptions.

// File: rtl/i2c_sel_pkg.sv
package i2c_sel_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_ARRAY = 2'b01,
    TGT_PROT  = 2'b10
  } target_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } phase_e;

  // bus events seen by the control, one cycle each
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaBit;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;
endpackage

// File: rtl/i2c_sel_datapath.sv
module i2c_sel_datapath
  import i2c_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output busEv_t            ev,
  output logic              sclLvl,
  output logic [BYTE_W-1:0] rxShift,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              txMsb
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclQ;
  logic sdaQ;
  logic sclS;
  logic sdaS;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sclLvl = sclS;

  always_comb begin
    ev.sclRise = sclS & ~sclQ;
    ev.sclFall = ~sclS & sclQ;
    ev.startEv = sclS & sclQ & sdaQ & ~sdaS;
    ev.stopEv  = sclS & sclQ & ~sdaQ & sdaS;
    ev.sdaBit  = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      bitCnt  <= '0;
    end else begin
      if (ctl.shiftIn)
        rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (ctl.loadTx)
        txShift <= rdData;
      else if (ctl.shiftTx)
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (ctl.clrCnt)
        bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  assign txMsb = txShift[BYTE_W-1];
endmodule

// File: rtl/i2c_sel_decode.sv
module i2c_sel_decode
  import i2c_sel_pkg::*;
#(
  parameter logic [3:0] ARRAY_ID = 4'b1010,
  parameter logic [3:0] PROT_ID  = 4'b0110
) (
  input  logic [BYTE_W-1:0] selByte,
  input  logic [2:0]        chipEn,
  input  logic              protEnable,
  output logic              hit,
  output target_e           target
);
  logic addrOk;

  assign addrOk = (selByte[3:1] == chipEn);

  always_comb begin
    target = TGT_NONE;
    if (addrOk && selByte[7:4] == ARRAY_ID)
      target = TGT_ARRAY;
    else if (addrOk && protEnable && selByte[7:4] == PROT_ID)
      target = TGT_PROT;
  end

  assign hit = (target != TGT_NONE);
endmodule

// File: rtl/i2c_sel_control.sv
module i2c_sel_control
  import i2c_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic              busy,
  input  logic              ackEnable,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              rwIn,
  input  logic              selHit,
  input  target_e           selTgt,
  input  logic              txMsb,
  output dpCtl_t            ctl,
  output logic              sdaOe,
  output logic              selActive,
  output target_e           selTarget,
  output logic              rwBit,
  output logic              rxStrobe,
  output logic              rdLoad,
  output logic              writeTrig
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  phase_e  state, stateN;
  logic    isSel, isSelN;
  logic    ackDrv, ackDrvN;
  logic    afterAck, afterN;
  logic    rwQ, rwN;
  logic    selQ, selN;
  target_e tgtQ, tgtN;
  logic    nackQ, nackN;

  always_comb begin
    stateN    = state;
    isSelN    = isSel;
    ackDrvN   = ackDrv;
    afterN    = afterAck;
    rwN       = rwQ;
    selN      = selQ;
    tgtN      = tgtQ;
    nackN     = nackQ;
    ctl       = '0;
    rxStrobe  = 1'b0;
    writeTrig = 1'b0;
    if (busy) begin
      stateN  = ST_IDLE;
      selN    = 1'b0;
      afterN  = 1'b0;
      ackDrvN = 1'b0;
      tgtN    = TGT_NONE;
    end else if (ev.startEv) begin
      stateN     = ST_RX;
      ctl.clrCnt = 1'b1;
      isSelN     = 1'b1;
      selN       = 1'b0;
      afterN     = 1'b0;
      ackDrvN    = 1'b0;
      tgtN       = TGT_NONE;
    end else if (ev.stopEv) begin
      writeTrig = afterAck;
      stateN    = ST_IDLE;
      selN      = 1'b0;
      afterN    = 1'b0;
      ackDrvN   = 1'b0;
      tgtN      = TGT_NONE;
    end else begin
      unique case (state)
        ST_RX: begin
          if (ev.sclRise && bitCnt != FULL_CNT)
            ctl.shiftIn = 1'b1;
          if (ev.sclFall) begin
            afterN = 1'b0;
            if (bitCnt == FULL_CNT) begin
              if (isSel) begin
                if (selHit) begin
                  stateN  = ST_ACK;
                  ackDrvN = 1'b1;
                  selN    = 1'b1;
                  tgtN    = selTgt;
                  rwN     = rwIn;
                end else begin
                  stateN = ST_IDLE;
                end
              end else begin
                rxStrobe = 1'b1;
                stateN   = ST_ACK;
                ackDrvN  = ackEnable;
              end
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            ctl.clrCnt = 1'b1;
            ackDrvN    = 1'b0;
            if (isSel && rwQ) begin
              stateN     = ST_TX;
              ctl.loadTx = 1'b1;
            end else if (isSel) begin
              stateN = ST_RX;
              isSelN = 1'b0;
            end else if (ackDrv) begin
              stateN = ST_RX;
              afterN = 1'b1;
            end else begin
              stateN = ST_IDLE;
              selN   = 1'b0;
              tgtN   = TGT_NONE;
            end
          end
        end
        ST_TX: begin
          if (ev.sclFall) begin
            if (bitCnt == LAST_TX)
              stateN = ST_RACK;
            else
              ctl.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (ev.sclRise)
            nackN = ev.sdaBit;
          if (ev.sclFall) begin
            if (nackQ) begin
              stateN = ST_IDLE;
              selN   = 1'b0;
              tgtN   = TGT_NONE;
            end else begin
              stateN     = ST_TX;
              ctl.clrCnt = 1'b1;
              ctl.loadTx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isSel    <= 1'b0;
      ackDrv   <= 1'b0;
      afterAck <= 1'b0;
      rwQ      <= 1'b0;
      selQ     <= 1'b0;
      tgtQ     <= TGT_NONE;
      nackQ    <= 1'b0;
    end else begin
      state    <= stateN;
      isSel    <= isSelN;
      ackDrv   <= ackDrvN;
      afterAck <= afterN;
      rwQ      <= rwN;
      selQ     <= selN;
      tgtQ     <= tgtN;
      nackQ    <= nackN;
    end
  end

  assign sdaOe     = (state == ST_ACK && ackDrv) || (state == ST_TX && !txMsb);
  assign selActive = selQ;
  assign selTarget = tgtQ;
  assign rwBit     = rwQ;
  assign rdLoad    = ctl.loadTx;
endmodule

// File: rtl/i2c_sel_front.sv
module i2c_sel_front
  import i2c_sel_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ARRAY_ID    = 4'b1010,
  parameter logic [3:0] PROT_ID     = 4'b0110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] chipEn,
  input  logic       protEnable,
  input  logic       ackEnable,
  input  logic       busy,
  input  logic [7:0] rdData,
  output logic       rdLoad,
  output logic       selActive,
  output logic [1:0] selTarget,
  output logic       rwBit,
  output logic [7:0] rxByte,
  output logic       rxStrobe,
  output logic       writeTrig
);
  busEv_t            ev;
  dpCtl_t            ctl;
  logic              sclLvl;
  logic [BYTE_W-1:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;
  logic              txMsb;
  logic              selHit;
  target_e           decTgt;
  target_e           tgtOut;

  i2c_sel_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .rdData(rdData), .ev(ev), .sclLvl(sclLvl), .rxShift(rxShift),
    .bitCnt(bitCnt), .txMsb(txMsb)
  );

  i2c_sel_decode #(.ARRAY_ID(ARRAY_ID), .PROT_ID(PROT_ID)) u_dec (
    .selByte(rxShift), .chipEn(chipEn), .protEnable(protEnable),
    .hit(selHit), .target(decTgt)
  );

  i2c_sel_control u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .busy(busy), .ackEnable(ackEnable),
    .bitCnt(bitCnt), .rwIn(rxShift[0]), .selHit(selHit), .selTgt(decTgt),
    .txMsb(txMsb), .ctl(ctl), .sdaOe(sdaOe), .selActive(selActive),
    .selTarget(tgtOut), .rwBit(rwBit), .rxStrobe(rxStrobe),
    .rdLoad(rdLoad), .writeTrig(writeTrig)
  );

  assign selTarget = tgtOut;
  assign rxByte    = rxShift;
endmodule

// File: rtl/i2c_sel_front_chk.sv
module i2c_sel_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       sclLvl,
  input logic       sdaOe,
  input logic       selActive,
  input logic [1:0] selTarget,
  input logic       rxStrobe,
  input logic       rdLoad,
  input logic       writeTrig
);
  AST_TARGET_VALID: assert property (@(posedge clk) disable iff (!rstN)
    selActive |-> selTarget != 2'b00); // R2

  AST_NO_ORPHAN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |-> (!rxStrobe && !rdLoad)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxStrobe && rdLoad)); // R5

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    writeTrig |=> (!writeTrig && !selActive)); // R6

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && sdaOe != $past(sdaOe)) |-> !sclLvl); // R7

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!sdaOe && !selActive)); // R9
endmodule

bind i2c_sel_front i2c_sel_front_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclLvl(sclLvl), .sdaOe(sdaOe),
  .selActive(selActive), .selTarget(selTarget), .rxStrobe(rxStrobe),
  .rdLoad(rdLoad), .writeTrig(writeTrig)
);

// File: tb/i2c_sel_front_test.sv
module i2c_sel_front_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [2:0] chipEn = 3'b101;
  logic protEnable = 1'b1;
  logic ackEnable = 1'b1;
  logic busy = 1'b0;
  logic [7:0] rdData;
  logic sdaOe, rdLoad, selActive, rwBit, rxStrobe, writeTrig;
  logic [1:0] selTarget;
  logic [7:0] rxByte;
  logic sdaLine;

  int checks = 0;
  int errors = 0;
  int rxCnt = 0;
  int trigCnt = 0;
  int rdCnt = 0;
  logic [7:0] rxLog [0:31];
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  function automatic logic [7:0] pat(input int k);
    return 8'hC3 ^ 8'(k * 8'h35);
  endfunction

  initial rdData = pat(0);

  always @(posedge clk) begin
    if (rxStrobe) begin
      rxLog[rxCnt % 32] <= rxByte;
      rxCnt <= rxCnt + 1;
    end
    if (writeTrig) trigCnt <= trigCnt + 1;
    if (rdLoad) begin
      rdCnt  <= rdCnt + 1;
      rdData <= pat(rdCnt + 1);
    end
  end

  i2c_sel_front uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .chipEn(chipEn), .protEnable(protEnable), .ackEnable(ackEnable),
    .busy(busy), .rdData(rdData), .rdLoad(rdLoad), .selActive(selActive),
    .selTarget(selTarget), .rwBit(rwBit), .rxByte(rxByte),
    .rxStrobe(rxStrobe), .writeTrig(writeTrig)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (5) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    sdaDrv = b;    waitQ();
    sclDrv = 1'b1; waitQ();
    waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    b = sdaLine;   waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(ack);
  endtask

  task automatic recvByte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) readBit(v[i]);
  endtask

  initial begin
    logic ack;
    logic expAck;
    logic [7:0] got;
    logic b;
    int base;
    int tb;

    repeat (4) @(negedge clk);
    // R1 reset state
    check(sdaOe == 1'b0, "R1 sdaOe", sdaOe, 0);
    check(selActive == 1'b0, "R1 selActive", selActive, 0);
    check(selTarget == 2'b00, "R1 selTarget", selTarget, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(rxStrobe == 1'b0 && rdLoad == 1'b0 && writeTrig == 1'b0, "R1 strobes", 0, 0);

    // R2 R3 R4 R10: sweep every type code and address
    for (int t = 0; t < 16; t++) begin
      for (int a = 0; a < 8; a++) begin
        startCond();
        sendByte({4'(t), 3'(a), 1'b0}, ack);
        expAck = ((t == 10) || (t == 6)) && (a == 5);
        check(ack == !expAck, "R2/R4 select ack", ack, !expAck);
        check(selActive == expAck, "R4 selActive", selActive, expAck);
        tb = !expAck ? 0 : (t == 10 ? 1 : 2);
        check(selTarget == 2'(tb), "R2/R3 selTarget", selTarget, tb);
        if (!expAck) begin
          sendByte(8'h00, ack);
          check(ack == 1'b1, "R4 idle after mismatch", ack, 1);
        end
        stopCond();
        check(selActive == 1'b0, "R10 cleared by stop", selActive, 0);
      end
    end
    check(rxCnt == 0, "R4 no strobe from mismatch", rxCnt, 0);
    check(trigCnt == 0, "R6 no trigger on select only", trigCnt, 0);

    // R2: sweep chip-enable pins, read bit captured
    for (int c = 0; c < 8; c++) begin
      chipEn = 3'(c);
      startCond();
      sendByte({4'b1010, 3'(c), 1'b1}, ack);
      check(ack == 1'b0, "R2 chipEn sweep ack", ack, 0);
      check(rwBit == 1'b1, "R2 rwBit", rwBit, 1);
      recvByte(got);
      writeBit(1'b1);
      stopCond();
    end
    chipEn = 3'b101;

    // R3: protection code masked
    protEnable = 1'b0;
    startCond();
    sendByte(8'h6A, ack);
    check(ack == 1'b1, "R3 masked prot code", ack, 1);
    stopCond();
    protEnable = 1'b1;

    // R5 R6: write of four bytes, then STOP in tenth slot
    base = rxCnt;
    startCond();
    sendByte(8'hAA, ack);
    check(ack == 1'b0 && rwBit == 1'b0, "R2 write select", ack, 0);
    sendByte(8'h3C, ack); check(ack == 1'b0, "R5 ack byte0", ack, 0);
    sendByte(8'hA5, ack); check(ack == 1'b0, "R5 ack byte1", ack, 0);
    sendByte(8'hFF, ack); check(ack == 1'b0, "R5 ack byte2", ack, 0);
    sendByte(8'h01, ack); check(ack == 1'b0, "R5 ack byte3", ack, 0);
    stopCond();
    repeat (4) @(negedge clk);
    check(rxCnt - base == 4, "R5 strobe count", rxCnt - base, 4);
    check(rxLog[base % 32] == 8'h3C, "R5 byte0", rxLog[base % 32], 8'h3C);
    check(rxLog[(base + 1) % 32] == 8'hA5, "R5 byte1", rxLog[(base + 1) % 32], 8'hA5);
    check(rxLog[(base + 2) % 32] == 8'hFF, "R5 byte2", rxLog[(base + 2) % 32], 8'hFF);
    check(rxLog[(base + 3) % 32] == 8'h01, "R5 byte3", rxLog[(base + 3) % 32], 8'h01);
    check(trigCnt == 1, "R6 trigger after ack", trigCnt, 1);

    // R5 R6: ackEnable low gives NoAck, no trigger
    ackEnable = 1'b0;
    startCond();
    sendByte(8'hAA, ack);
    sendByte(8'h42, ack);
    check(ack == 1'b1, "R5 NoAck when disabled", ack, 1);
    check(selActive == 1'b0, "R5 idle after NoAck", selActive, 0);
    stopCond();
    repeat (4) @(negedge clk);
    check(trigCnt == 1, "R6 no trigger after NoAck", trigCnt, 1);
    ackEnable = 1'b1;

    // R6: STOP mid-byte
    startCond();
    sendByte(8'hAA, ack);
    sendByte(8'h11, ack);
    writeBit(1'b1); writeBit(1'b0);
    stopCond();
    repeat (4) @(negedge clk);
    check(trigCnt == 1, "R6 no trigger mid-byte", trigCnt, 1);

    // R7 R8: random read with repeated START
    base = rdCnt;
    startCond();
    sendByte(8'hAA, ack);
    sendByte(8'h10, ack);
    startCond();
    sendByte(8'hAB, ack);
    check(ack == 1'b0 && selTarget == 2'b01, "R8 read select after restart", ack, 0);
    for (int k = 0; k < 3; k++) begin
      recvByte(got);
      check(got == pat(base + k), "R7 read byte", got, pat(base + k));
      writeBit(k == 2);
    end
    readBit(b);
    check(b == 1'b1 && sdaOe == 1'b0, "R7 released after NoAck", b, 1);
    stopCond();
    repeat (4) @(negedge clk);
    check(rdCnt - base == 3, "R7 rdLoad count", rdCnt - base, 3);
    check(trigCnt == 1, "R6 no trigger on read", trigCnt, 1);

    // R8: restart mid-byte
    startCond();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    startCond();
    sendByte(8'hAA, ack);
    check(ack == 1'b0, "R8 restart clears count", ack, 0);
    stopCond();

    // R9: busy ignores the bus
    base = rxCnt;
    busy = 1'b1;
    repeat (2) @(negedge clk);
    startCond();
    sendByte(8'hAA, ack);
    check(ack == 1'b1, "R9 no ack while busy", ack, 1);
    sendByte(8'h55, ack);
    check(ack == 1'b1 && selActive == 1'b0, "R9 still ignored", ack, 1);
    stopCond();
    check(rxCnt == base, "R9 no strobe while busy", rxCnt, base);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    startCond();
    sendByte(8'hAA, ack);
    check(ack == 1'b0, "R9 resumes after busy", ack, 0);
    stopCond();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule